// File: doc/BRIEF.md
# Write-Only Serial Control Register Bank

This block lets a host microcontroller configure a video processing path over a two-wire serial bus. It acts as a slave receiver with a fixed 7-bit device address and accepts only write transfers. A transfer carries the device address, then a register index, then one or more data bytes. The index advances after every data byte, so one transfer can fill several registers in turn. The block drives SDA low only to acknowledge, as an open-drain output, and never returns data.

Four 8-bit registers are decoded into control fields. These are an operating mode, frame and split-screen options, signal-source and noise-reduction controls, an input word-width select, a three-bit frame grey level, two five-bit adaptation thresholds and a raw test byte.

The operating mode is held in two copies. The requested copy changes as soon as the byte is written. The active copy, which drives the datapath, loads the requested value only in a clock cycle where the vertical sync input and the data-request input are both high. This keeps a mode change aligned with the vertical blanking interval.

Top module: `serctl_regbank`

## Requirements
- R1: After reset the register views read index 0 = 0x03 (mode 00, word width bit set, noise reduction on), index 1 = 0x04 (grey 0, lower threshold 4), index 2 = 0x10 (upper threshold 16), index 3 = 0x00, and the active mode is 00.
- R2: An address byte equal to 0010101 followed by a write bit (byte value 0x2A) is acknowledged. Any other address byte is not acknowledged, and this includes the read byte 0x2B. The rest of that transfer is not acknowledged and writes nothing.
- R3: After the address, the next byte is the register index and each later byte is data stored at the current index. Every accepted byte is acknowledged by pulling SDA low during the ninth SCL high phase, and SDA is released after the ninth falling SCL edge.
- R4: The index increments after each data byte, so consecutive data bytes in one transfer land in consecutive registers.
- R5: Data written to an index above 3 is acknowledged but changes no register. The index saturates at 255 and never wraps back to 0.
- R6: Index 0 layout: bits 7:6 requested mode (00 normal, 01 multi-picture, 10 still-in-picture, 11 picture-in-still), bit 5 narrow frame, bit 4 unused and read as 0, bit 3 split screen, bit 2 VCR source, bit 1 noise-reduction enable, bit 0 8-bit input word width.
- R7: Index 1 layout: bits 7:5 frame grey level (0 black to 7 white), bits 4:0 lower threshold. Index 2 layout: bits 4:0 upper threshold, bits 7:5 unused. Index 3 is stored whole.
- R8: The active mode loads the requested mode one clock after a cycle in which vertical sync and data request are both high. It holds its value in every other cycle.
- R9: A STOP ends the transfer at any point, and a partially received byte is discarded. A repeated START restarts address reception without an intervening STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| vsync_i | input | 1 | Vertical sync, high during vertical blanking |
| dreq_i | input | 1 | Data-request input that gates the mode change |
| mode_o | output | 2 | Active operating mode |
| mode_req_o | output | 2 | Requested operating mode as written |
| narrow_frame_o | output | 1 | Narrow frame enable |
| split_screen_o | output | 1 | Split-screen demonstration enable |
| vcr_mode_o | output | 1 | VCR source, adaptation off |
| nr_enable_o | output | 1 | Noise reduction enable |
| word8_o | output | 1 | 1 selects 8-bit input words, 0 selects 7-bit |
| frame_grey_o | output | 3 | Frame grey level |
| thr_low_o | output | 5 | Lower adaptation threshold |
| thr_high_o | output | 5 | Upper adaptation threshold |
| test_ctl_o | output | 8 | Test register contents |

## Verification
The assertions assume that SCL and SDA are asynchronous but slow. Each bus phase must last well beyond the two-flop synchroniser delay, and SDA must change only while SCL is low, except for START and STOP. They also take vertical sync and data request as synchronous to the system clock. The stimulus holds every SCL half-phase for eight system clocks and changes SDA a full phase after SCL falls. It drives vertical sync and data request on falling clock edges, so these inputs stay within those assumptions.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NUM_REGS = 4;
    localparam logic [6:0]  DEV_ADDR = 7'b0010101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        rx_state_e         st;
        rx_phase_e         ph;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shf;
        logic [BYTE_W-1:0] sub;
        logic              drv;
        logic              wr;
        logic [BYTE_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              scl_p;
        logic              sda_p;
    } rx_regs_t;

    typedef struct packed {
        logic [1:0] mode_req;
        logic       narrow;
        logic       split;
        logic       vcr;
        logic       nr_en;
        logic       word8;
        logic [2:0] grey;
        logic [4:0] thr_lo;
        logic [4:0] thr_hi;
        logic [7:0] test;
    } ctl_t;

    typedef struct packed {
        ctl_t       ctl;
        logic [1:0] mode_act;
    } bank_regs_t;

    localparam ctl_t CTL_RESET = '{
        mode_req: 2'b00, narrow: 1'b0, split: 1'b0, vcr: 1'b0,
        nr_en: 1'b1, word8: 1'b1, grey: 3'd0, thr_lo: 5'd4,
        thr_hi: 5'd16, test: 8'h00
    };

endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int unsigned WIDTH     = 2,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {(STAGES*WIDTH){RESET_BIT}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/serctl_bus_rx.sv
module serctl_bus_rx
    import serctl_pkg::*;
#(
    parameter logic [6:0] ADDR = DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              wr_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              drv_o
);

    localparam logic [BYTE_W-1:0] ADDR_WR  = {ADDR, 1'b0};
    localparam logic [3:0]        BYTE_CNT = 4'(BYTE_W);
    localparam logic [BYTE_W-1:0] SUB_MAX  = '1;

    rx_regs_t q, d;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    always_comb begin
        scl_rise = scl_s & ~q.scl_p;
        scl_fall = ~scl_s & q.scl_p;
        start_ev = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_ev  = scl_s & q.scl_p & ~q.sda_p & sda_s;

        d       = q;
        d.wr    = 1'b0;
        d.scl_p = scl_s;
        d.sda_p = sda_s;

        if (start_ev) begin
            d.st  = ST_RECV;
            d.ph  = PH_ADDR;
            d.cnt = '0;
            d.drv = 1'b0;
        end else if (stop_ev) begin
            d.st  = ST_IDLE;
            d.drv = 1'b0;
        end else begin
            case (q.st)
                ST_RECV: begin
                    if (scl_rise && q.cnt < BYTE_CNT) begin
                        d.shf = {q.shf[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BYTE_CNT) begin
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.shf == ADDR_WR) begin
                                    d.st  = ST_ACK;
                                    d.drv = 1'b1;
                                    d.ph  = PH_SUB;
                                end else begin
                                    d.st = ST_SKIP;
                                end
                            end
                            PH_SUB: begin
                                d.sub = q.shf;
                                d.st  = ST_ACK;
                                d.drv = 1'b1;
                                d.ph  = PH_DATA;
                            end
                            default: begin
                                d.wr      = 1'b1;
                                d.wr_addr = q.sub;
                                d.wr_data = q.shf;
                                if (q.sub != SUB_MAX) begin
                                    d.sub = q.sub + 1'b1;
                                end
                                d.st  = ST_ACK;
                                d.drv = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.drv = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_RECV;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, cnt: '0, shf: '0, sub: '0,
                   drv: 1'b0, wr: 1'b0, wr_addr: '0, wr_data: '0,
                   scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign wr_o      = q.wr;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;
    assign drv_o     = q.drv;

    // R4: a register write is a single-cycle strobe
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);

    // R5: index steps by one after a data byte and sticks at its maximum
    p_sub_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> (q.sub == ((q.wr_addr == SUB_MAX) ? SUB_MAX : q.wr_addr + 1'b1)));

    // R3: SDA is only pulled during an acknowledge slot
    p_drive_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.drv |-> (q.st == ST_ACK));

    // R9: a STOP releases the line
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !q.drv);

endmodule

// File: rtl/serctl_bank.sv
module serctl_bank
    import serctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              vsync_i,
    input  logic              dreq_i,
    output ctl_t              ctl_o,
    output logic [1:0]        mode_act_o
);

    bank_regs_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            case (wr_addr_i)
                8'd0: begin
                    d.ctl.mode_req = wr_data_i[7:6];
                    d.ctl.narrow   = wr_data_i[5];
                    d.ctl.split    = wr_data_i[3];
                    d.ctl.vcr      = wr_data_i[2];
                    d.ctl.nr_en    = wr_data_i[1];
                    d.ctl.word8    = wr_data_i[0];
                end
                8'd1: begin
                    d.ctl.grey   = wr_data_i[7:5];
                    d.ctl.thr_lo = wr_data_i[4:0];
                end
                8'd2: begin
                    d.ctl.thr_hi = wr_data_i[4:0];
                end
                8'd3: begin
                    d.ctl.test = wr_data_i;
                end
                default: ;
            endcase
        end
        if (vsync_i && dreq_i) begin
            d.mode_act = q.ctl.mode_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctl: CTL_RESET, mode_act: 2'b00};
        end else begin
            q <= d;
        end
    end

    assign ctl_o      = q.ctl;
    assign mode_act_o = q.mode_act;

    // R5: writes beyond the last register leave every field alone
    p_high_sub_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_addr_i >= BYTE_W'(NUM_REGS)) |=> $stable(q.ctl));

    // R8: active mode holds outside the gated window
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync_i && dreq_i) |=> $stable(q.mode_act));

    // R8: inside the window the active mode takes the requested value
    p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && dreq_i) |=> (q.mode_act == $past(q.ctl.mode_req)));

endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank
    import serctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       vsync_i,
    input  logic       dreq_i,
    output logic [1:0] mode_o,
    output logic [1:0] mode_req_o,
    output logic       narrow_frame_o,
    output logic       split_screen_o,
    output logic       vcr_mode_o,
    output logic       nr_enable_o,
    output logic       word8_o,
    output logic [2:0] frame_grey_o,
    output logic [4:0] thr_low_o,
    output logic [4:0] thr_high_o,
    output logic [7:0] test_ctl_o
);

    logic [1:0]        bus_s;
    logic              wr;
    logic [BYTE_W-1:0] wr_addr, wr_data;
    ctl_t              ctl;

    serctl_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_BIT (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (bus_s)
    );

    serctl_bus_rx #(
        .ADDR (DEV_ADDR)
    ) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .wr_o      (wr),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .drv_o     (sda_pull_o)
    );

    serctl_bank i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .vsync_i    (vsync_i),
        .dreq_i     (dreq_i),
        .ctl_o      (ctl),
        .mode_act_o (mode_o)
    );

    assign mode_req_o     = ctl.mode_req;
    assign narrow_frame_o = ctl.narrow;
    assign split_screen_o = ctl.split;
    assign vcr_mode_o     = ctl.vcr;
    assign nr_enable_o    = ctl.nr_en;
    assign word8_o        = ctl.word8;
    assign frame_grey_o   = ctl.grey;
    assign thr_low_o      = ctl.thr_lo;
    assign thr_high_o     = ctl.thr_hi;
    assign test_ctl_o     = ctl.test;

endmodule

// File: tb/test_serctl_regbank.sv
module test_serctl_regbank;

    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic vsync = 1'b0, dreq = 1'b0;
    logic sda_pull, sda_line;
    logic [1:0] mode, mode_req;
    logic narrow, split, vcr, nr_en, word8;
    logic [2:0] grey;
    logic [4:0] thr_lo, thr_hi;
    logic [7:0] test_ctl;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    serctl_regbank i_serctl_regbank (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .vsync_i(vsync), .dreq_i(dreq),
        .mode_o(mode), .mode_req_o(mode_req), .narrow_frame_o(narrow),
        .split_screen_o(split), .vcr_mode_o(vcr), .nr_enable_o(nr_en),
        .word8_o(word8), .frame_grey_o(grey), .thr_low_o(thr_lo),
        .thr_high_o(thr_hi), .test_ctl_o(test_ctl)
    );

    // stimulus/expected table: {index, data, expected view}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'hC6, 8'hC6}, {8'h00, 8'h3D, 8'h2D},
        {8'h01, 8'hA5, 8'hA5}, {8'h01, 8'h1F, 8'h1F},
        {8'h02, 8'hFF, 8'h1F}, {8'h02, 8'h0A, 8'h0A},
        {8'h03, 8'h5A, 8'h5A}, {8'h00, 8'h10, 8'h00}
    };

    function automatic logic [7:0] view(input logic [1:0] idx);
        case (idx)
            2'd0:    return {mode_req, narrow, 1'b0, split, vcr, nr_en, word8};
            2'd1:    return {grey, thr_lo};
            2'd2:    return {3'b000, thr_hi};
            default: return test_ctl;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b;    wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q / 2);
        ack = sda_pull;
        wait_q(Q - Q / 2);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic write_one(input logic [7:0] idx, input logic [7:0] dat);
        logic a;
        bus_start();
        bus_byte(AW, a);  check("R2 address ack", a, 1);
        bus_byte(idx, a); check("R3 index ack", a, 1);
        bus_byte(dat, a); check("R3 data ack", a, 1);
        bus_stop();
        wait_q(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(5);

        // R1 reset state
        check("R1 reg0", view(0), 8'h03);
        check("R1 reg1", view(1), 8'h04);
        check("R1 reg2", view(2), 8'h10);
        check("R1 reg3", view(3), 8'h00);
        check("R1 active mode", mode, 2'b00);
        check("R1 sda released", sda_pull, 1'b0);

        // R6 R7 table walk
        for (int v = 0; v < 8; v++) begin
            write_one(VEC[v][23:16], VEC[v][15:8]);
            check("R6 R7 field view", view(VEC[v][17:16]), VEC[v][7:0]);
        end
        check("R8 mode held without window", mode, 2'b00);

        // R4 burst with auto-increment
        bus_start();
        bus_byte(AW, a);    check("R2 ack", a, 1);
        bus_byte(8'h00, a); check("R3 ack", a, 1);
        bus_byte(8'h81, a); check("R4 ack0", a, 1);
        bus_byte(8'hE2, a); check("R4 ack1", a, 1);
        bus_byte(8'h13, a); check("R4 ack2", a, 1);
        bus_byte(8'h77, a); check("R4 ack3", a, 1);
        bus_stop(); wait_q(4);
        check("R4 reg0", view(0), 8'h81);
        check("R4 reg1", view(1), 8'hE2);
        check("R4 reg2", view(2), 8'h13);
        check("R4 reg3", view(3), 8'h77);

        // R2 wrong address
        bus_start();
        bus_byte(8'h2C, a); check("R2 wrong address nack", a, 0);
        bus_byte(8'h01, a); check("R2 skipped byte nack", a, 0);
        bus_byte(8'h55, a); check("R2 skipped data nack", a, 0);
        bus_stop(); wait_q(4);
        check("R2 reg1 untouched", view(1), 8'hE2);

        // R2 read direction refused
        bus_start();
        bus_byte(8'h2B, a); check("R2 read nack", a, 0);
        bus_stop(); wait_q(4);

        // R5 running past the last register
        bus_start();
        bus_byte(AW, a);    check("R2 ack", a, 1);
        bus_byte(8'h03, a); check("R3 ack", a, 1);
        bus_byte(8'h99, a); check("R5 ack idx3", a, 1);
        bus_byte(8'hAA, a); check("R5 ack idx4", a, 1);
        bus_stop(); wait_q(4);
        check("R5 reg3 written", view(3), 8'h99);
        check("R5 reg0 untouched", view(0), 8'h81);

        // R5 saturation, no wrap to 0
        bus_start();
        bus_byte(AW, a);    check("R2 ack", a, 1);
        bus_byte(8'hFE, a); check("R3 ack", a, 1);
        bus_byte(8'h11, a); check("R5 ack FE", a, 1);
        bus_byte(8'h22, a); check("R5 ack FF", a, 1);
        bus_byte(8'h33, a); check("R5 ack sat", a, 1);
        bus_stop(); wait_q(4);
        check("R5 no wrap reg0", view(0), 8'h81);
        check("R5 no wrap reg1", view(1), 8'hE2);

        // R9 STOP in mid byte
        bus_start();
        bus_byte(AW, a);
        bus_byte(8'h01, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b0);
        bus_stop(); wait_q(4);
        check("R9 partial byte dropped", view(1), 8'hE2);
        check("R9 line released", sda_pull, 1'b0);
        write_one(8'h01, 8'h33);
        check("R9 next transfer works", view(1), 8'h33);

        // R9 repeated START
        bus_start();
        bus_byte(AW, a);
        bus_byte(8'h02, a);
        bus_start();
        bus_byte(AW, a);    check("R9 restart address ack", a, 1);
        bus_byte(8'h01, a);
        bus_byte(8'h44, a); check("R9 restart data ack", a, 1);
        bus_stop(); wait_q(4);
        check("R9 restart write", view(1), 8'h44);
        check("R9 reg2 untouched", view(2), 8'h13);

        // R8 gated mode transfer
        write_one(8'h00, 8'hC3);
        check("R8 requested mode", mode_req, 2'b11);
        check("R8 active unchanged", mode, 2'b00);
        vsync = 1'b1; wait_q(3); vsync = 1'b0; wait_q(2);
        check("R8 vsync alone", mode, 2'b00);
        dreq = 1'b1; wait_q(3); dreq = 1'b0; wait_q(2);
        check("R8 dreq alone", mode, 2'b00);
        vsync = 1'b1; dreq = 1'b1; wait_q(2);
        check("R8 window load", mode, 2'b11);
        vsync = 1'b0; dreq = 1'b0; wait_q(2);
        write_one(8'h00, 8'h43);
        check("R8 request updated", mode_req, 2'b01);
        check("R8 active held", mode, 2'b11);
        vsync = 1'b1; dreq = 1'b1; wait_q(2);
        vsync = 1'b0; dreq = 1'b0; wait_q(2);
        check("R8 second load", mode, 2'b01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule